// File: doc/BRIEF.md
# Quasi-Resonant Valley Lockout Selector

This block decides on which valley of the drain-voltage ringing the next switching cycle of a quasi-resonant converter begins. A 10-bit current-reference code, which is a fraction of full scale, is compared against two sets of thresholds. One set applies while the reference falls and the other while it rises. The result is a valley band that stays locked until the reference crosses one of those thresholds. A line-range flag moves every band one valley higher when the input voltage is high. When the reference drops to a low level, the block enters frequency foldback, and each cycle then carries an extra dead time.

Within each switching cycle, an end-of-demagnetisation pulse restarts the valley count and latches the valley target. Falling-edge pulses from the zero-crossing comparator then advance the count. If the comparator stays quiet for a timeout, the block inserts a substitute valley. When the count reaches the target, a one-cycle turn-on strobe is issued to the gate-drive logic.

Top module: `vly_lockout_top`

## Requirements
- R1: After reset, valley_num is 1, foldback is 0, turn_on is 0 and synth_valley is 0.
- R2: With a full-scale reference (code 1023), valley_num is 1 at low line (line_high=0) and 2 at high line (line_high=1).
- R3: While the reference falls, the band index (0..4) moves up by one step per clock when ref_code drops below the threshold of the current band. The thresholds are codes 818, 664, 511 and 358 for bands 0, 1, 2 and 3.
- R4: While the reference rises, the band index moves down by one step per clock when ref_code exceeds the return threshold of the band below. The return thresholds are codes 920, 767, 613 and 460 for bands 1, 2, 3 and 4.
- R5: valley_num equals band index + 1 + line flag, giving 1..5 at low line and 2..6 at high line. The line flag is registered, so valley_num follows line_high one clock later.
- R6: A reference that lies between a band's falling and rising thresholds leaves valley_num unchanged for any duration.
- R7: foldback sets one clock after ref_code is below 255 and clears one clock after ref_code is above 358.
- R8: A demag_end pulse clears the valley count and latches valley_num as the target. turn_on is high for exactly the clock after the edge at which the count reaches the target.
- R9: While a cycle is hunting and no zcd_fall arrives for TMO_CYC consecutive clocks, a substitute valley is counted. synth_valley pulses in the following clock.
- R10: If foldback is set at the demag_end edge, the next dead_cycles clocks ignore zcd_fall and the timeout does not run.
- R11: After turn_on, zcd_fall pulses produce no turn_on until the next demag_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_code | input | 10 | Current-reference level, 1023 = full scale |
| line_high | input | 1 | 1 = high-line input range |
| zcd_fall | input | 1 | One-clock pulse per detected valley |
| demag_end | input | 1 | One-clock pulse at end of demagnetisation |
| dead_cycles | input | 12 | Foldback dead time in clocks |
| valley_num | output | 3 | Selected valley, 1..6 |
| foldback | output | 1 | Frequency-foldback mode active |
| turn_on | output | 1 | One-clock turn-on strobe |
| synth_valley | output | 1 | One-clock pulse when a substitute valley was counted |

## Verification
The reference is swept slowly downward and then upward through every band. This tells the falling thresholds apart from the rising ones, and a hold inside each hysteresis gap shows that the lock holds. Switching cycles are run with regular comparator pulses at both line ranges, which separates the band-to-valley offset from the counting itself. Cycles with no comparator pulses at all exercise the timeout path. Foldback cycles with pulses inside the dead window show that those pulses are ignored, and pulses after a strobe show that they cannot retrigger.

// File: rtl/vly_pkg.sv
package vly_pkg;
  localparam int unsigned NUM_STEPS = 4;

  function automatic int unsigned pct_code(input int unsigned full, input int unsigned pct);
    return (full * pct) / 100;
  endfunction

  function automatic int unsigned fall_pct(input int unsigned k);
    case (k)
      0: return 80;
      1: return 65;
      2: return 50;
      default: return 35;
    endcase
  endfunction

  function automatic int unsigned rise_pct(input int unsigned k);
    case (k)
      0: return 90;
      1: return 75;
      2: return 60;
      default: return 45;
    endcase
  endfunction

  localparam int unsigned FOLD_ON_PCT  = 25;
  localparam int unsigned FOLD_OFF_PCT = 35;
endpackage

// File: rtl/vly_band_sel.sv
module vly_band_sel
  import vly_pkg::*;
#(
  parameter int REF_W = 10,
  parameter int VLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] ref_code,
  input  logic             line_high,
  output logic [VLY_W-1:0] valley_num,
  output logic             foldback,
  output logic [2:0]       band_idx
);
  localparam int unsigned FULL = (1 << REF_W) - 1;

  logic [REF_W-1:0] fall_thr [NUM_STEPS];
  logic [REF_W-1:0] rise_thr [NUM_STEPS];
  localparam logic [REF_W-1:0] FOLD_ON  = REF_W'(pct_code(FULL, FOLD_ON_PCT));
  localparam logic [REF_W-1:0] FOLD_OFF = REF_W'(pct_code(FULL, FOLD_OFF_PCT));

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_thr
    assign fall_thr[k] = REF_W'(pct_code(FULL, fall_pct(k)));
    assign rise_thr[k] = REF_W'(pct_code(FULL, rise_pct(k)));
  end

  logic [2:0] band_q, band_d;
  logic       line_q;
  logic       fold_q, fold_d;
  logic [1:0] idx_cur, idx_below;

  assign idx_cur   = band_q[1:0];
  assign idx_below = 2'(band_q - 3'd1);

  always_comb begin
    band_d = band_q;
    if (band_q < 3'(NUM_STEPS) && ref_code < fall_thr[idx_cur])
      band_d = band_q + 3'd1;
    else if (band_q != 3'd0 && ref_code > rise_thr[idx_below])
      band_d = band_q - 3'd1;
  end

  always_comb begin
    fold_d = fold_q;
    if (ref_code < FOLD_ON)
      fold_d = 1'b1;
    else if (ref_code > FOLD_OFF)
      fold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= '0;
      line_q <= 1'b0;
      fold_q <= 1'b0;
    end else begin
      band_q <= band_d;
      line_q <= line_high;
      fold_q <= fold_d;
    end
  end

  assign band_idx   = band_q;
  assign foldback   = fold_q;
  assign valley_num = VLY_W'(band_q) + VLY_W'(1) + VLY_W'(line_q);
endmodule

// File: rtl/vly_hunt.sv
module vly_hunt #(
  parameter int VLY_W   = 3,
  parameter int TMO_CYC = 1625,
  parameter int DEAD_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              demag_end,
  input  logic              zcd_fall,
  input  logic [VLY_W-1:0]  target,
  input  logic              fold_mode,
  input  logic [DEAD_W-1:0] dead_cycles,
  output logic              turn_on,
  output logic              synth_valley,
  output logic              hunting,
  output logic              valley_evt,
  output logic              tmo_hit
);
  localparam int TMR_W = $clog2(TMO_CYC + 1);

  logic [TMR_W-1:0]  tmr_q;
  logic [DEAD_W-1:0] dead_q;
  logic [VLY_W-1:0]  cnt_q, tgt_q, cnt_inc;
  logic              hunt_q;

  assign tmo_hit    = (tmr_q == TMR_W'(TMO_CYC - 1));
  assign valley_evt = hunt_q && (dead_q == '0) && (zcd_fall || tmo_hit);
  assign cnt_inc    = cnt_q + VLY_W'(1);
  assign hunting    = hunt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt_q       <= 1'b0;
      tmr_q        <= '0;
      dead_q       <= '0;
      cnt_q        <= '0;
      tgt_q        <= '0;
      turn_on      <= 1'b0;
      synth_valley <= 1'b0;
    end else begin
      turn_on      <= 1'b0;
      synth_valley <= 1'b0;
      if (demag_end) begin
        hunt_q <= 1'b1;
        tmr_q  <= '0;
        cnt_q  <= '0;
        tgt_q  <= target;
        dead_q <= fold_mode ? dead_cycles : '0;
      end else if (hunt_q) begin
        if (dead_q != '0) begin
          dead_q <= dead_q - DEAD_W'(1);
        end else if (valley_evt) begin
          tmr_q        <= '0;
          cnt_q        <= cnt_inc;
          synth_valley <= !zcd_fall;
          if (cnt_inc == tgt_q) begin
            turn_on <= 1'b1;
            hunt_q  <= 1'b0;
          end
        end else begin
          tmr_q <= tmr_q + TMR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vly_lockout_top.sv
module vly_lockout_top #(
  parameter int REF_W   = 10,
  parameter int VLY_W   = 3,
  parameter int TMO_CYC = 1625,
  parameter int DEAD_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REF_W-1:0]  ref_code,
  input  logic              line_high,
  input  logic              zcd_fall,
  input  logic              demag_end,
  input  logic [DEAD_W-1:0] dead_cycles,
  output logic [VLY_W-1:0]  valley_num,
  output logic              foldback,
  output logic              turn_on,
  output logic              synth_valley
);
  logic [2:0] band_idx;
  logic       hunting, valley_evt, tmo_hit;

  vly_band_sel #(.REF_W(REF_W), .VLY_W(VLY_W)) u_band (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_code   (ref_code),
    .line_high  (line_high),
    .valley_num (valley_num),
    .foldback   (foldback),
    .band_idx   (band_idx)
  );

  vly_hunt #(.VLY_W(VLY_W), .TMO_CYC(TMO_CYC), .DEAD_W(DEAD_W)) u_hunt (
    .clk          (clk),
    .rst_n        (rst_n),
    .demag_end    (demag_end),
    .zcd_fall     (zcd_fall),
    .target       (valley_num),
    .fold_mode    (foldback),
    .dead_cycles  (dead_cycles),
    .turn_on      (turn_on),
    .synth_valley (synth_valley),
    .hunting      (hunting),
    .valley_evt   (valley_evt),
    .tmo_hit      (tmo_hit)
  );
endmodule

// File: rtl/vly_lockout_chk.sv
module vly_lockout_chk #(
  parameter int REF_W = 10,
  parameter int VLY_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REF_W-1:0] ref_code,
  input logic             zcd_fall,
  input logic             demag_end,
  input logic [VLY_W-1:0] valley_num,
  input logic             foldback,
  input logic             turn_on,
  input logic             synth_valley,
  input logic             hunting,
  input logic             valley_evt
);
  localparam int unsigned FULL = (1 << REF_W) - 1;
  localparam int unsigned FON  = (FULL * 25) / 100;
  localparam int unsigned FOFF = (FULL * 35) / 100;

  assert_valley_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valley_num >= VLY_W'(1) && valley_num <= VLY_W'(6));

  assert_fold_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(foldback) |-> $past(ref_code) < REF_W'(FON));

  assert_fold_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(foldback) |-> $past(ref_code) > REF_W'(FOFF));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on |=> !turn_on);

  assert_strobe_from_valley_R8: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on |-> $past(valley_evt) && $past(hunting) && !$past(demag_end));

  assert_synth_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    synth_valley |-> !$past(zcd_fall));

  assert_no_retrigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hunting && !demag_end) |=> !turn_on);
endmodule

bind vly_lockout_top vly_lockout_chk #(.REF_W(REF_W), .VLY_W(VLY_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_code     (ref_code),
  .zcd_fall     (zcd_fall),
  .demag_end    (demag_end),
  .valley_num   (valley_num),
  .foldback     (foldback),
  .turn_on      (turn_on),
  .synth_valley (synth_valley),
  .hunting      (hunting),
  .valley_evt   (valley_evt)
);

// File: tb/vly_lockout_top_tb_top.sv
module vly_lockout_top_tb_top;
  localparam int TMO = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  ref_code = 10'd1023;
  logic        line_high = 1'b0;
  logic        zcd_fall = 1'b0;
  logic        demag_end = 1'b0;
  logic [11:0] dead_cycles = 12'd0;
  logic [2:0]  valley_num;
  logic        foldback, turn_on, synth_valley;

  always #2 clk = ~clk;

  vly_lockout_top #(.TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_code(ref_code), .line_high(line_high),
    .zcd_fall(zcd_fall), .demag_end(demag_end), .dead_cycles(dead_cycles),
    .valley_num(valley_num), .foldback(foldback), .turn_on(turn_on),
    .synth_valley(synth_valley));

  int n_chk = 0, n_err = 0, cyc = 0;
  string phase = "R1";
  int n_on = 0, n_syn = 0;

  // behavioural reference
  int m_band = 0, m_line = 0, m_fold = 0, m_hunt = 0, m_cnt = 0, m_tmr = 0;
  int m_dead = 0, m_tgt = 0, m_on = 0, m_syn = 0;
  int fall_c[4] = '{818, 664, 511, 358};
  int rise_c[4] = '{920, 767, 613, 460};

  function automatic int m_valley();
    return m_band + 1 + m_line;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_band = 0; m_line = 0; m_fold = 0; m_hunt = 0; m_cnt = 0;
      m_tmr = 0; m_dead = 0; m_tgt = 0; m_on = 0; m_syn = 0;
    end else begin
      int vn, fold_old, nb;
      bit quiet_hit;
      vn = m_valley();
      fold_old = m_fold;
      m_on = 0; m_syn = 0;
      if (demag_end) begin
        m_hunt = 1; m_cnt = 0; m_tmr = 0; m_tgt = vn;
        m_dead = fold_old ? int'(dead_cycles) : 0;
      end else if (m_hunt == 1) begin
        if (m_dead > 0) m_dead--;
        else begin
          quiet_hit = (m_tmr == TMO - 1);
          if (zcd_fall || quiet_hit) begin
            m_tmr = 0; m_cnt++;
            m_syn = zcd_fall ? 0 : 1;
            if (m_cnt == m_tgt) begin m_on = 1; m_hunt = 0; end
          end else m_tmr++;
        end
      end
      nb = m_band;
      if (m_band < 4 && int'(ref_code) < fall_c[m_band]) nb = m_band + 1;
      else if (m_band > 0 && int'(ref_code) > rise_c[m_band-1]) nb = m_band - 1;
      m_band = nb;
      m_line = line_high ? 1 : 0;
      if (ref_code < 10'd255) m_fold = 1;
      else if (ref_code > 10'd358) m_fold = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (turn_on) n_on++;
    if (synth_valley) n_syn++;
    if (rst_n) begin
      check(phase, int'(valley_num), m_valley(), "valley_num");
      check(phase, int'(foldback), m_fold, "foldback");
      check(phase, int'(turn_on), m_on, "turn_on");
      check(phase, int'(synth_valley), m_syn, "synth_valley");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_demag();
    demag_end = 1'b1; tick(1); demag_end = 1'b0;
  endtask

  task automatic pulse_zcd();
    zcd_fall = 1'b1; tick(1); zcd_fall = 1'b0;
  endtask

  task automatic run_cycle(input int nvalleys);
    pulse_demag();
    for (int i = 0; i < nvalleys; i++) begin tick(2); pulse_zcd(); end
    tick(1);
  endtask

  int on0;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    tick(3);
    phase = "R1";
    check("R1", int'(valley_num), 1, "reset valley");
    check("R1", int'(foldback), 0, "reset foldback");
    check("R1", int'(turn_on), 0, "reset turn_on");
    rst_n = 1'b1;
    tick(2);

    // R2 / R8: full reference, low line → first valley
    phase = "R2";
    check("R2", int'(valley_num), 1, "low line full ref");
    on0 = n_on;
    pulse_demag(); tick(2); pulse_zcd();
    check("R8", int'(turn_on), 1, "strobe after 1st valley");
    tick(1);
    check("R8", n_on - on0, 1, "single strobe");
    // R11: more valleys after strobe ignored
    phase = "R11";
    on0 = n_on;
    pulse_zcd(); tick(1); pulse_zcd(); tick(2);
    check("R11", n_on - on0, 0, "no strobe after turn-on");

    // R5: high line
    phase = "R5";
    line_high = 1'b1; tick(1);
    check("R5", int'(valley_num), 2, "high line full ref");
    on0 = n_on;
    run_cycle(1);
    check("R5", n_on - on0, 0, "one valley not enough at high line");
    run_cycle(2);
    check("R5", n_on - on0, 1, "strobe at 2nd valley");
    line_high = 1'b0; tick(2);

    // R3: falling sweep with holds in each gap (R6)
    phase = "R3";
    ref_code = 10'd818; tick(2);
    check("R3", int'(valley_num), 1, "at 818 no move");
    ref_code = 10'd817; tick(1);
    check("R3", int'(valley_num), 2, "below 818");
    phase = "R6";
    ref_code = 10'd900; tick(30);
    check("R6", int'(valley_num), 2, "hold in gap");
    phase = "R3";
    ref_code = 10'd663; tick(1);
    check("R3", int'(valley_num), 3, "below 664");
    ref_code = 10'd510; tick(1);
    check("R3", int'(valley_num), 4, "below 511");
    ref_code = 10'd357; tick(1);
    check("R3", int'(valley_num), 5, "below 358");
    ref_code = 10'd0; tick(3);
    check("R3", int'(valley_num), 5, "last band clamps");
    line_high = 1'b1; tick(1);
    check("R5", int'(valley_num), 6, "high line max 6");

    // R9: timeout valleys at valley 6 (no comparator pulses)
    phase = "R9";
    dead_cycles = 12'd0;
    on0 = n_on; n_syn = 0;
    pulse_demag(); tick(6 * TMO + 2);
    check("R9", n_syn, 6, "substitute valleys");
    check("R9", n_on - on0, 1, "strobe after timeouts");
    line_high = 1'b0; tick(1);

    // R10: foldback with dead time, pulses inside dead window ignored
    phase = "R10";
    check("R7", int'(foldback), 1, "foldback active at 0");
    dead_cycles = 12'd10;
    on0 = n_on;
    pulse_demag();
    for (int i = 0; i < 4; i++) begin pulse_zcd(); tick(1); end
    check("R10", n_on - on0, 0, "dead window ignores valleys");
    tick(4);
    for (int i = 0; i < 5; i++) begin pulse_zcd(); tick(1); end
    check("R10", n_on - on0, 1, "strobe after dead time");

    // R4 / R7: rising sweep
    phase = "R4";
    ref_code = 10'd358; tick(3);
    check("R7", int'(foldback), 1, "foldback held at 358");
    ref_code = 10'd359; tick(1);
    check("R7", int'(foldback), 0, "foldback exit");
    check("R4", int'(valley_num), 5, "359 keeps band 4");
    ref_code = 10'd461; tick(1);
    check("R4", int'(valley_num), 4, "above 460");
    ref_code = 10'd614; tick(1);
    check("R4", int'(valley_num), 3, "above 613");
    ref_code = 10'd768; tick(1);
    check("R4", int'(valley_num), 2, "above 767");
    ref_code = 10'd920; tick(3);
    check("R6", int'(valley_num), 2, "at 920 still locked");
    ref_code = 10'd921; tick(1);
    check("R4", int'(valley_num), 1, "above 920");
    ref_code = 10'd255; tick(2);
    check("R7", int'(foldback), 0, "no foldback at 255");
    ref_code = 10'd254; tick(1);
    check("R7", int'(foldback), 1, "foldback at 254");
    ref_code = 10'd1023; tick(10);

    // mixed cycles at valley 3
    phase = "R8";
    ref_code = 10'd600; tick(6);
    on0 = n_on;
    run_cycle(2);
    check("R8", n_on - on0, 0, "two valleys short of 3rd");
    run_cycle(3);
    check("R8", n_on - on0, 1, "strobe at 3rd valley");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule